// File: doc/BRIEF.md
# Parity-Checked Carry-Select Adder

A purely combinational 64-bit adder that detects its own faults while it works. Each operand arrives with one parity bit. The block forms the per-bit propagate terms a single time. Those terms feed the adder slices and also the parity check of the inputs.

The operand is split into six slices. From the least significant end they are 8, 8, 12, 12, 12 and 12 bits wide. The lowest slice is built once. Each higher slice is built twice, one copy assuming a carry-in of 0 and one assuming a carry-in of 1. The carry from the slice below picks which copy goes to the output. Every slice produces two sum rails, one true and one inverted, and each rail has its own carry chain, so every slice also produces two copies of its carry-out.

The block reports three error indications:
- a parity error when the inputs fail their parity;
- a rail error when the selected rails disagree;
- a combined error flag, the OR of the other two.

Top module: `csa_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the 65-bit unsigned sum of `a_i` and `b_i` for every input pair.
- R2: `par_err_o` is 1 when `pa_i ^ pb_i` differs from the XOR of all 128 operand bits.
- R3: `par_err_o` is 0 when `pa_i` is the XOR of all bits of `a_i` and `pb_i` is the XOR of all bits of `b_i`.
- R4: `rail_err_o` is 0 for every input in a fault-free adder. Every selected true sum bit is the complement of its inverted bit, and the two copies of every selected carry agree.
- R5: `err_o` equals `par_err_o | rail_err_o` for all inputs.
- R6: A carry that is generated in one slice and ripples across a slice boundary reaches the next slice correctly. The slice boundaries are at bit positions 8, 16, 28, 40 and 52.
- R7: A carry generated in bit 0 that propagates through every higher bit appears at `cout_o`, with `sum_o` equal to 0.
- R8: `cout_o` is 1 when bits 52 to 63 of both operands generate a carry on their own, whatever the lower bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| pa_i | input | 1 | Parity bit of `a_i` (XOR of its bits) |
| pb_i | input | 1 | Parity bit of `b_i` (XOR of its bits) |
| sum_o | output | 64 | Sum, low 64 bits |
| cout_o | output | 1 | Carry out of bit 63 |
| par_err_o | output | 1 | Input parity does not match the propagate terms |
| rail_err_o | output | 1 | Selected rails or carry copies disagree |
| err_o | output | 1 | OR of the two error outputs |

## Verification
The hardest case to reach from the ports is a carry that must cross one slice boundary, or all of them, through the carry-in-1 copies. Random operands seldom produce long propagate runs. The stimulus therefore builds operands that are all ones below a chosen boundary, plus one, so that the select chain at each boundary is driven in turn. It also runs an all-ones-plus-one case that walks the carry through every slice to `cout_o`. Parity faults are injected by flipping one parity bit against otherwise correct operands.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int N_BLK  = 6;
  localparam int N_LOW  = 2;
  localparam int LOW_W  = 8;
  localparam int HIGH_W = 12;
  localparam int DATA_W = N_LOW * LOW_W + (N_BLK - N_LOW) * HIGH_W;

  // width of slice k
  function automatic int blk_w(input int k);
    return (k < N_LOW) ? LOW_W : HIGH_W;
  endfunction

  // lowest bit position of slice k (k == N_BLK gives DATA_W)
  function automatic int blk_lsb(input int k);
    return (k <= N_LOW) ? k * LOW_W : N_LOW * LOW_W + (k - N_LOW) * HIGH_W;
  endfunction
endpackage

// File: rtl/csa_prop_gen.sv
module csa_prop_gen #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic         par_o
);
  assign p_o   = a_i ^ b_i;
  assign par_o = ^p_o;
endmodule

// File: rtl/csa_ripple_blk.sv
module csa_ripple_blk #(
  parameter int   W   = 8,
  parameter logic CIN = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] sum_n_o,
  output logic         carry_a_o,
  output logic         carry_b_o
);
  // two independent carry chains: chain A feeds the true rail,
  // chain B feeds the inverted rail
  always_comb begin
    logic ca;
    logic cb;
    ca = CIN;
    cb = CIN;
    for (int i = 0; i < W; i++) begin
      sum_o[i]   = p_i[i] ^ ca;
      sum_n_o[i] = ~(p_i[i] ^ cb);
      ca = (a_i[i] & b_i[i]) | (p_i[i] & ca);
      cb = (a_i[i] & b_i[i]) | (p_i[i] & cb);
    end
    carry_a_o = ca;
    carry_b_o = cb;
  end
endmodule

// File: rtl/csa_sel.sv
module csa_sel #(
  parameter int W = 12
) (
  input  logic         sel_i,
  input  logic [W-1:0] s0_i,
  input  logic [W-1:0] sn0_i,
  input  logic         ca0_i,
  input  logic         cb0_i,
  input  logic [W-1:0] s1_i,
  input  logic [W-1:0] sn1_i,
  input  logic         ca1_i,
  input  logic         cb1_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] sn_o,
  output logic         ca_o,
  output logic         cb_o
);
  assign s_o  = sel_i ? s1_i  : s0_i;
  assign sn_o = sel_i ? sn1_i : sn0_i;
  assign ca_o = sel_i ? ca1_i : ca0_i;
  assign cb_o = sel_i ? cb1_i : cb0_i;
endmodule

// File: rtl/csa_adder.sv
module csa_adder
  import csa_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              pa_i,
  input  logic              pb_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              par_err_o,
  output logic              rail_err_o,
  output logic              err_o
);
  logic [DATA_W-1:0] prop;
  logic              prop_par;
  logic [DATA_W-1:0] sum_t;     // selected true rail
  logic [DATA_W-1:0] sum_n;     // selected inverted rail
  logic [N_BLK-1:0]  blk_carry;   // selected carry, copy A (drives muxes)
  logic [N_BLK-1:0]  blk_carry_b; // selected carry, copy B
  logic [N_BLK-1:0]  rail_bad;

  csa_prop_gen #(.W(DATA_W)) prop_i (
    .a_i(a_i), .b_i(b_i), .p_o(prop), .par_o(prop_par)
  );

  csa_ripple_blk #(.W(blk_w(0)), .CIN(1'b0)) blk0_i (
    .a_i(a_i[blk_w(0)-1:0]), .b_i(b_i[blk_w(0)-1:0]), .p_i(prop[blk_w(0)-1:0]),
    .sum_o(sum_t[blk_w(0)-1:0]), .sum_n_o(sum_n[blk_w(0)-1:0]),
    .carry_a_o(blk_carry[0]), .carry_b_o(blk_carry_b[0])
  );

  for (genvar k = 1; k < N_BLK; k++) begin : g_blk
    localparam int L = blk_lsb(k);
    localparam int W = blk_w(k);
    logic [W-1:0] s0, sn0, s1, sn1;
    logic         ca0, cb0, ca1, cb1;

    csa_ripple_blk #(.W(W), .CIN(1'b0)) c0_i (
      .a_i(a_i[L +: W]), .b_i(b_i[L +: W]), .p_i(prop[L +: W]),
      .sum_o(s0), .sum_n_o(sn0), .carry_a_o(ca0), .carry_b_o(cb0)
    );
    csa_ripple_blk #(.W(W), .CIN(1'b1)) c1_i (
      .a_i(a_i[L +: W]), .b_i(b_i[L +: W]), .p_i(prop[L +: W]),
      .sum_o(s1), .sum_n_o(sn1), .carry_a_o(ca1), .carry_b_o(cb1)
    );
    csa_sel #(.W(W)) sel_i (
      .sel_i(blk_carry[k-1]),
      .s0_i(s0), .sn0_i(sn0), .ca0_i(ca0), .cb0_i(cb0),
      .s1_i(s1), .sn1_i(sn1), .ca1_i(ca1), .cb1_i(cb1),
      .s_o(sum_t[L +: W]), .sn_o(sum_n[L +: W]),
      .ca_o(blk_carry[k]), .cb_o(blk_carry_b[k])
    );
  end

  // two-rail check per slice
  for (genvar k = 0; k < N_BLK; k++) begin : g_rail
    localparam int L = blk_lsb(k);
    localparam int W = blk_w(k);
    assign rail_bad[k] = ~(&(sum_t[L +: W] ^ sum_n[L +: W]))
                       | (blk_carry[k] ^ blk_carry_b[k]);
  end

  assign sum_o      = sum_t;
  assign cout_o     = blk_carry[N_BLK-1];
  assign par_err_o  = prop_par ^ pa_i ^ pb_i;
  assign rail_err_o = |rail_bad;
  assign err_o      = par_err_o | rail_err_o;
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk
  import csa_pkg::*;
(
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              pa_i,
  input logic              pb_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              cout_o,
  input logic              par_err_o,
  input logic              rail_err_o,
  input logic              err_o,
  input logic [N_BLK-1:0]  blk_carry
);
  always_comb begin
    logic [DATA_W:0] full;
    full = {1'b0, a_i} + {1'b0, b_i};
    assert_sum_R1: assert ({cout_o, sum_o} == full);
    // R2/R3: parity error iff the two operand parity residues differ
    assert_parity_R2: assert (par_err_o == ((pa_i ^ (^a_i)) != (pb_i ^ (^b_i))));
    assert_rails_R4: assert (!rail_err_o);
    assert_err_or_R5: assert (err_o == (par_err_o | rail_err_o));
    assert_cout_R8: assert (!(a_i[DATA_W-1] && b_i[DATA_W-1]) || cout_o);
  end

  // R6: every selected slice carry equals the carry out of the bits below it
  always_comb begin
    for (int k = 0; k < N_BLK; k++) begin
      logic [DATA_W:0] msk;
      logic [DATA_W:0] part;
      msk  = ({{DATA_W{1'b0}}, 1'b1} << blk_lsb(k + 1)) - 1'b1;
      part = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk);
      assert_blk_carry_R6: assert (blk_carry[k] == part[blk_lsb(k + 1)]);
    end
  end
endmodule

bind csa_adder csa_adder_chk chk_i (
  .a_i(a_i), .b_i(b_i), .pa_i(pa_i), .pb_i(pb_i),
  .sum_o(sum_o), .cout_o(cout_o), .par_err_o(par_err_o),
  .rail_err_o(rail_err_o), .err_o(err_o), .blk_carry(blk_carry)
);

// File: tb/csa_adder_tb_top.sv
module csa_adder_tb_top;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] a = '0, b = '0;
  logic          pa = 1'b0, pb = 1'b0;
  logic [DW-1:0] sum;
  logic          cout, par_err, rail_err, err;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  csa_adder dut_i (
    .a_i(a), .b_i(b), .pa_i(pa), .pb_i(pb),
    .sum_o(sum), .cout_o(cout), .par_err_o(par_err),
    .rail_err_o(rail_err), .err_o(err)
  );

  // bit-serial reference sum
  function automatic logic [DW:0] ref_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW:0] r;
    logic c;
    c = 1'b0;
    for (int i = 0; i < DW; i++) begin
      r[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] | y[i]));
    end
    r[DW] = c;
    return r;
  endfunction

  function automatic logic parity(input logic [DW-1:0] x);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DW; i++) r = r ^ x[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW:0] got, input logic [DW:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply one vector with correct or flipped parity, check everything at negedge
  task automatic apply(input string tag, input logic [DW-1:0] x, input logic [DW-1:0] y,
                       input logic flip_a, input logic flip_b);
    logic exp_par;
    @(posedge clk);
    a  = x;
    b  = y;
    pa = parity(x) ^ flip_a;
    pb = parity(y) ^ flip_b;
    exp_par = flip_a ^ flip_b;
    @(negedge clk);
    check({tag, " R1 sum"}, {cout, sum}, ref_add(x, y));
    check({tag, (exp_par ? " R2 par_err" : " R3 par_err")}, {{DW{1'b0}}, par_err}, {{DW{1'b0}}, exp_par});
    check({tag, " R4 rail_err"}, {{DW{1'b0}}, rail_err}, '0);
    check({tag, " R5 err"}, {{DW{1'b0}}, err}, {{DW{1'b0}}, exp_par});
  endtask

  task automatic t_zero();
    apply("zero", '0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_basic();
    apply("basic1", 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 1'b0, 1'b0);
    apply("basic2", 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 1'b0, 1'b0);
    apply("basic3", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_boundaries();   // R6
    int bnd[5] = '{8, 16, 28, 40, 52};
    foreach (bnd[j]) begin
      logic [DW-1:0] m;
      m = (64'h1 << bnd[j]) - 64'h1;
      apply($sformatf("R6 ripple@%0d", bnd[j]), m, 64'h1, 1'b0, 1'b0);
      apply($sformatf("R6 gen@%0d", bnd[j]), 64'h1 << (bnd[j] - 1), 64'h1 << (bnd[j] - 1), 1'b0, 1'b0);
    end
  endtask

  task automatic t_full_ripple();  // R7
    apply("R7 full", '1, 64'h1, 1'b0, 1'b0);
    check("R7 sum zero", {1'b0, sum}, '0);
    check("R7 cout", {{DW{1'b0}}, cout}, {{DW{1'b0}}, 1'b1});
  endtask

  task automatic t_top_gen();      // R8
    apply("R8 top", 64'hF000_0000_0000_0000, 64'h1000_0000_0000_0000, 1'b0, 1'b0);
    check("R8 cout", {{DW{1'b0}}, cout}, {{DW{1'b0}}, 1'b1});
  endtask

  task automatic t_parity();       // R2 / R3
    apply("R2 flip_a", 64'hdead_beef_0123_4567, 64'h0000_ffff_0000_ffff, 1'b1, 1'b0);
    apply("R2 flip_b", 64'h0f0f_0f0f_0f0f_0f0f, 64'h1111_1111_1111_1111, 1'b0, 1'b1);
    apply("R3 flip_both", 64'h0f0f_0f0f_0f0f_0f0f, 64'h1111_1111_1111_1111, 1'b1, 1'b1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      logic [DW-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      apply("rand", x, y, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_basic();
    t_boundaries();
    t_full_ripple();
    t_top_gen();
    t_parity();
    t_random();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule